// File: doc/BRIEF.md
# Two-View Timing Coincidence Trigger

This block decides, once per calorimeter cluster, whether a track report from the bend-plane view and a track report from the non-bend-plane view were raised on neighbouring symbol cycles. Each report arrives as a wide vector. The upper `HDR_W` bits of the vector hold the symbol-cycle offset of the report, and the lower `MAP_W` bits hold the bitmap of the element that fired. The block keeps only the offset and discards the bitmap.

A cluster is processed in two phases. In the **fill** phase, every non-bend-view offset is written into a small content-addressable table. The table is emptied when the cluster begins. In the **search** phase, the bend-view offsets are presented one per beat. Each one is compared in a single cycle against every valid table entry. A pair counts as coincident when the stored offset is exactly one less than the presented offset.

The first coincidence produces a one-cycle accept pulse. Any bend-view beats that remain for that cluster are then swallowed. If the final bend-view beat passes with no coincidence, a one-cycle no-match pulse is produced instead.

The controller has four states:
- `S_IDLE` waits for a cluster start. The transition *start* clears the table and moves to `S_LOAD`.
- `S_LOAD` stores non-bend offsets. The transition *fill done* moves to `S_PROBE`.
- `S_PROBE` searches the table:
  - *hit on last beat* returns to `S_IDLE` with accept.
  - *hit before last beat* moves to `S_DRAIN` with accept.
  - *miss on last beat* returns to `S_IDLE` with no-match.
- `S_DRAIN` discards beats. The transition *last beat* returns to `S_IDLE`.

Top module: `coin_detect`

## Requirements
- R1: After reset the block is in `S_IDLE` and `accept`, `no_match` and `overflow` are all 0.
- R2: Only bits [VEC_W-1 : VEC_W-HDR_W] of a vector (the offset) take part in matching. The lower MAP_W bitmap bits have no effect, while every offset bit, including the most significant, does.
- R3: A search beat with offset P matches when some stored offset equals P-1. A stored offset equal to P or P+1 does not match, and P = 0 never matches.
- R4: `accept` is high for exactly the one cycle after the first matching search beat. Later bend-view beats of the same cluster produce neither `accept` nor `no_match`.
- R5: `no_match` is high for exactly the one cycle after a search beat that is flagged last and does not match. It is never high together with `accept`.
- R6: A `clus_start` accepted in `S_IDLE` empties the table, so offsets loaded for an earlier cluster never match.
- R7: A load beat that arrives while `DEPTH` offsets are already stored is dropped and sets `overflow`. `overflow` stays high until the next accepted `clus_start` clears it.
- R8: Bend-view beats outside `S_PROBE`/`S_DRAIN` and non-bend beats outside `S_LOAD` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clus_start | input | 1 | Begin a new cluster (honoured in `S_IDLE`) |
| nb_valid | input | 1 | Non-bend-view vector present |
| nb_vec | input | VEC_W | Non-bend-view vector, offset in the top HDR_W bits |
| nb_done | input | 1 | All non-bend vectors of the cluster have been sent |
| bd_valid | input | 1 | Bend-view vector present |
| bd_vec | input | VEC_W | Bend-view vector, offset in the top HDR_W bits |
| bd_last | input | 1 | Marks the final bend-view vector of the cluster |
| accept | output | 1 | One-cycle trigger-accept pulse |
| no_match | output | 1 | One-cycle pulse when the cluster ends without a coincidence |
| overflow | output | 1 | Sticky flag set when a load beat finds the table full |

## Verification
The central sweep loads three offsets and then runs one single-beat cluster for every search offset from 0 to 24. This separates the one-cycle-earlier rule from equality, from one-cycle-later, and from the zero-offset edge.

Further clusters cover the remaining behaviour:
- Vectors that share an offset but carry different bitmaps, and offsets that differ only in the top bit, show that only the offset matters.
- A multi-beat cluster with an early hit shows that later beats are swallowed.
- An all-miss cluster and an empty load show the no-match pulse.
- Back-to-back clusters show that the table is cleared between clusters.
- Loading past the table depth shows the overflow flag and that the extra offset is dropped.
- Beats sent in the wrong phase show that they are ignored.

// File: rtl/coin_pkg.sv
package coin_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_LOAD  = 2'd1,
        S_PROBE = 2'd2,
        S_DRAIN = 2'd3
    } coin_state_e;
endpackage

// File: rtl/coin_cam.sv
module coin_cam #(
    parameter int KEY_W = 64,
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [KEY_W-1:0] look_key,
    output logic             hit,
    output logic             full,
    output logic [CNT_W-1:0] fill
);
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] hit_vec;
    logic             do_wr;

    assign full  = (fill == CNT_W'(DEPTH));
    assign do_wr = wr_en && !full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     fill <= '0;
        else if (clr)   fill <= '0;
        else if (do_wr) fill <= fill + 1'b1;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [KEY_W-1:0] key_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[i] <= 1'b0;
                key_q    <= '0;
            end else if (clr) begin
                vld_q[i] <= 1'b0;
            end else if (do_wr && fill == CNT_W'(i)) begin
                vld_q[i] <= 1'b1;
                key_q    <= wr_key;
            end
        end
        assign hit_vec[i] = vld_q[i] && (key_q == look_key);
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/coin_ctrl.sv
module coin_ctrl
    import coin_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clus_start,
    input  logic        nb_valid,
    input  logic        nb_done,
    input  logic        bd_valid,
    input  logic        bd_last,
    input  logic        hit,
    input  logic        full,
    output logic        cam_clr,
    output logic        cam_wr,
    output logic        accept,
    output logic        no_match,
    output logic        overflow,
    output coin_state_e state
);
    coin_state_e nxt;
    logic        probe_en;

    assign cam_clr  = (state == S_IDLE) && clus_start;
    assign cam_wr   = (state == S_LOAD) && nb_valid;
    assign probe_en = (state == S_PROBE) && bd_valid;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (clus_start) nxt = S_LOAD;
            S_LOAD:  if (nb_done) nxt = S_PROBE;
            S_PROBE: begin
                if (bd_valid) begin
                    if (hit)          nxt = bd_last ? S_IDLE : S_DRAIN;
                    else if (bd_last) nxt = S_IDLE;
                end
            end
            S_DRAIN: if (bd_valid && bd_last) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            accept   <= 1'b0;
            no_match <= 1'b0;
            overflow <= 1'b0;
        end else begin
            accept   <= probe_en && hit;
            no_match <= probe_en && !hit && bd_last;
            if (cam_clr)              overflow <= 1'b0;
            else if (cam_wr && full)  overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/coin_detect.sv
module coin_detect
    import coin_pkg::*;
#(
    parameter int HDR_W = 64,
    parameter int MAP_W = 512,
    parameter int DEPTH = 64,
    localparam int VEC_W = HDR_W + MAP_W,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clus_start,
    input  logic             nb_valid,
    input  logic [VEC_W-1:0] nb_vec,
    input  logic             nb_done,
    input  logic             bd_valid,
    input  logic [VEC_W-1:0] bd_vec,
    input  logic             bd_last,
    output logic             accept,
    output logic             no_match,
    output logic             overflow
);
    logic [HDR_W-1:0] nb_hdr, bd_hdr, look_key;
    logic             cam_hit, hit, full, cam_clr, cam_wr;
    logic [CNT_W-1:0] fill;
    coin_state_e      state;
    logic             unused_map;

    assign nb_hdr     = nb_vec[VEC_W-1 -: HDR_W];
    assign bd_hdr     = bd_vec[VEC_W-1 -: HDR_W];
    assign unused_map = ^{nb_vec[MAP_W-1:0], bd_vec[MAP_W-1:0]};
    assign look_key   = bd_hdr - 1'b1;
    assign hit        = cam_hit && (bd_hdr != '0);

    coin_cam #(.KEY_W(HDR_W), .DEPTH(DEPTH)) u_cam (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cam_clr),
        .wr_en    (cam_wr),
        .wr_key   (nb_hdr),
        .look_key (look_key),
        .hit      (cam_hit),
        .full     (full),
        .fill     (fill)
    );

    coin_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clus_start (clus_start),
        .nb_valid   (nb_valid),
        .nb_done    (nb_done),
        .bd_valid   (bd_valid),
        .bd_last    (bd_last),
        .hit        (hit),
        .full       (full),
        .cam_clr    (cam_clr),
        .cam_wr     (cam_wr),
        .accept     (accept),
        .no_match   (no_match),
        .overflow   (overflow),
        .state      (state)
    );
endmodule

// File: rtl/coin_detect_chk.sv
module coin_detect_chk
    import coin_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input coin_state_e      state,
    input logic             accept,
    input logic             no_match,
    input logic             overflow,
    input logic             nb_valid,
    input logic             bd_valid,
    input logic             bd_last,
    input logic [CNT_W-1:0] fill
);
    p_reset_idle_r1: assert property (@(posedge clk) $rose(rst_n) |-> (state == S_IDLE && !accept && !no_match && !overflow));

    p_accept_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(state == S_PROBE && bd_valid));

    p_drain_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DRAIN) |=> (!accept && !no_match));

    p_nomatch_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        no_match |-> $past(state == S_PROBE && bd_valid && bd_last));

    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && no_match));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOAD && $past(state) == S_IDLE) |-> (fill == '0));

    p_ovf_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(state == S_LOAD && nb_valid && fill == CNT_W'(DEPTH)));

    p_fill_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    p_load_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_LOAD) |=> $stable(fill) || fill == '0);
endmodule

bind coin_detect coin_detect_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .accept   (accept),
    .no_match (no_match),
    .overflow (overflow),
    .nb_valid (nb_valid),
    .bd_valid (bd_valid),
    .bd_last  (bd_last),
    .fill     (fill)
);

// File: tb/coin_detect_test.sv
`timescale 1ns/1ps
module coin_detect_test;
    localparam int HDR_W = 64;
    localparam int MAP_W = 512;
    localparam int DEPTH = 4;
    localparam int VEC_W = HDR_W + MAP_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clus_start = 1'b0, nb_valid = 1'b0, nb_done = 1'b0, bd_valid = 1'b0, bd_last = 1'b0;
    logic [VEC_W-1:0] nb_vec = '0, bd_vec = '0;
    logic accept, no_match, overflow;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    coin_detect #(.HDR_W(HDR_W), .MAP_W(MAP_W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .clus_start(clus_start),
        .nb_valid(nb_valid), .nb_vec(nb_vec), .nb_done(nb_done),
        .bd_valid(bd_valid), .bd_vec(bd_vec), .bd_last(bd_last),
        .accept(accept), .no_match(no_match), .overflow(overflow)
    );

    function automatic logic [VEC_W-1:0] mk(input logic [HDR_W-1:0] h, input logic [31:0] s);
        return {h, {(MAP_W/32){s}}};
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic start();
        clus_start = 1'b1; @(negedge clk); clus_start = 1'b0;
    endtask

    task automatic load(input logic [HDR_W-1:0] h, input logic [31:0] s);
        nb_valid = 1'b1; nb_vec = mk(h, s); @(negedge clk); nb_valid = 1'b0;
    endtask

    task automatic done();
        nb_done = 1'b1; @(negedge clk); nb_done = 1'b0;
    endtask

    task automatic probe(input logic [HDR_W-1:0] h, input logic last, input logic [31:0] s,
                         input logic ea, input logic en, input string tag);
        bd_valid = 1'b1; bd_last = last; bd_vec = mk(h, s);
        @(negedge clk);
        bd_valid = 1'b0; bd_last = 1'b0;
        chk(accept, ea, {tag, " accept"});
        chk(no_match, en, {tag, " no_match"});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(accept, 1'b0, "R1 accept");
        chk(no_match, 1'b0, "R1 no_match");
        chk(overflow, 1'b0, "R1 overflow");
        rst_n = 1'b1;
        @(negedge clk);
        chk(accept | no_match | overflow, 1'b0, "R1 after release");

        // R3: sweep probe offset against stored {5, 9, 20}
        for (int p = 0; p <= 24; p++) begin
            logic exp_hit;
            exp_hit = (p == 6) || (p == 10) || (p == 21);
            start(); load(5, 32'h11); load(9, 32'h22); load(20, 32'h33); done();
            probe(HDR_W'(p), 1'b1, 32'hA5A5_0000 + 32'(p), exp_hit, !exp_hit, $sformatf("R3 p=%0d", p));
        end

        // R2: bitmap ignored, all offset bits matter
        start(); load(40, 32'hFFFF_FFFF); done();
        probe(41, 1'b1, 32'h0, 1'b1, 1'b0, "R2 bitmap differs");
        start(); load(64'h8000_0000_0000_0030, 32'h5); done();
        probe(64'h31, 1'b1, 32'h5, 1'b0, 1'b1, "R2 top bit differs");

        // R4: first hit accepted, remainder swallowed
        start(); load(7, 32'h1); done();
        probe(3, 1'b0, 32'h2, 1'b0, 1'b0, "R4 early miss");
        probe(8, 1'b0, 32'h3, 1'b1, 1'b0, "R4 first hit");
        probe(8, 1'b0, 32'h4, 1'b0, 1'b0, "R4 drained hit");
        probe(4, 1'b1, 32'h5, 1'b0, 1'b0, "R4 drained last");
        start(); load(12, 32'h6); done();
        probe(13, 1'b1, 32'h7, 1'b1, 1'b0, "R4 next cluster");

        // R5: all-miss cluster and empty load
        start(); load(100, 32'h1); load(200, 32'h2); done();
        probe(50, 1'b0, 32'h3, 1'b0, 1'b0, "R5 miss 1");
        probe(150, 1'b0, 32'h4, 1'b0, 1'b0, "R5 miss 2");
        probe(250, 1'b1, 32'h5, 1'b0, 1'b1, "R5 last miss");
        start(); done();
        probe(1, 1'b1, 32'h6, 1'b0, 1'b1, "R5 empty table");

        // R6: previous cluster contents cleared
        start(); load(30, 32'h1); done();
        probe(31, 1'b1, 32'h2, 1'b1, 1'b0, "R6 first cluster");
        start(); load(77, 32'h3); done();
        probe(31, 1'b1, 32'h4, 1'b0, 1'b1, "R6 stale entry");

        // R7: overflow with DEPTH=4
        start();
        for (int k = 1; k <= 4; k++) load(HDR_W'(k), 32'(k));
        chk(overflow, 1'b0, "R7 full no overflow");
        load(5, 32'h9);
        chk(overflow, 1'b1, "R7 overflow set");
        done();
        chk(overflow, 1'b1, "R7 overflow held");
        probe(6, 1'b0, 32'h1, 1'b0, 1'b0, "R7 dropped entry");
        probe(5, 1'b1, 32'h1, 1'b1, 1'b0, "R7 kept entry");
        start();
        chk(overflow, 1'b0, "R7 overflow cleared");
        done();
        probe(9, 1'b1, 32'h0, 1'b0, 1'b1, "R7 close cluster");

        // R8: wrong-phase beats ignored
        start(); load(10, 32'h1);
        bd_valid = 1'b1; bd_last = 1'b1; bd_vec = mk(11, 32'h2);
        @(negedge clk);
        bd_valid = 1'b0; bd_last = 1'b0;
        @(negedge clk);
        chk(accept | no_match, 1'b0, "R8 bend beat in load");
        done();
        load(50, 32'h3);
        probe(51, 1'b0, 32'h4, 1'b0, 1'b0, "R8 load beat in probe");
        probe(11, 1'b1, 32'h5, 1'b1, 1'b0, "R8 still probing");
        bd_valid = 1'b1; bd_last = 1'b1; bd_vec = mk(11, 32'h6);
        @(negedge clk);
        bd_valid = 1'b0; bd_last = 1'b0;
        @(negedge clk);
        chk(accept | no_match, 1'b0, "R8 bend beat in idle");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule